// File: doc/BRIEF.md
# Buffered Dual-Write Register File

This block is a register file that takes up to two writes per clock even though its storage array has only one write port. When both write ports are active on different addresses, the port 0 value goes straight into the array. The port 1 value waits in a one-entry holding register and is copied into the array on the following cycle. While it waits, every read port whose address matches the held entry is served from that register instead of the array, so all reads see the value as if both writes had landed together.

Two-write cycles are expected to be uncommon. The held entry therefore usually drains in a cycle with no new write, at no cost. If new writes arrive while the entry is still waiting, the block raises `stall` for one cycle and ignores those writes. The requester keeps its write inputs unchanged until `stall` falls. A single new write to the waiting address does not stall: it overwrites the held value in place. Reads are combinational. Their number (two or three) and the widths are parameters.

Top module: `dwrf_top`

## Requirements
- R1: While `rst_n` is low, every address reads 0 on every read port, no entry is held, and `stall` is 0 whatever the write inputs are.
- R2: A single enabled write on either port, with no entry held, is visible on every read port from the clock edge on which it is taken.
- R3: Two enabled writes to different addresses in one cycle, with no entry held, are both visible from that edge on, and `stall` stays 0 in that cycle.
- R4: When both write ports are enabled on the same address in one cycle, the address takes the port 1 data and the port 0 data is discarded.
- R5: A held entry is copied into the array in the next cycle. After that it still reads back correctly, and writes to other addresses no longer stall.
- R6: `stall` is 1, within the same cycle, exactly when an entry is held and at least one write is requested, except in the R8 case. It stays high for one cycle if the inputs are held.
- R7: Writes presented while `stall` is 1 change no stored value. The same writes, held for the next cycle, are then taken normally.
- R8: If an entry is held and the cycle's only effective write (after R4 merging) targets the held address, the held data is replaced without a stall. The old value never reappears.
- R9: Any read port whose address equals the held address returns the held data. Other read ports return array contents.
- R10: Read ports are independent and combinational: each returns the data for its own address within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| w0_en | input | 1 | Write port 0 enable |
| w0_addr | input | AW | Write port 0 address |
| w0_data | input | DW | Write port 0 data |
| w1_en | input | 1 | Write port 1 enable |
| w1_addr | input | AW | Write port 1 address |
| w1_data | input | DW | Write port 1 data |
| rd_addr | input | NRD*AW | Read addresses, port p in bits [p*AW +: AW] |
| rd_data | output | NRD*DW | Read data, port p in bits [p*DW +: DW] |
| stall | output | 1 | Writes this cycle refused; hold them one more cycle |

## Verification
Assertions check several properties on every cycle. `stall` never lasts two cycles, and a stall always leaves the holding register empty. A clean two-write cycle parks the port 1 address and data. An in-place replacement keeps the entry and takes the new data. Any read that hits the held address returns the held value. End-to-end results can only be shown by the bench's scenarios, which compare every address against a two-write reference array after each vector. These cover the port 1 priority on equal addresses, that refused writes leave storage unchanged, and that a replaced entry never drains its stale value.

// File: rtl/dwrf_pkg.sv
`timescale 1ns/1ps
package dwrf_pkg;

   // What the holding register does at the next clock edge
   typedef enum logic [1:0] {
      HB_KEEP    = 2'd0,
      HB_FILL    = 2'd1,
      HB_DRAIN   = 2'd2,
      HB_REPLACE = 2'd3
   } hb_act_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dwrf_array.sv
`timescale 1ns/1ps
module dwrf_array #(
   parameter int DEPTH       = 16,
   parameter int DW          = 16,
   parameter int NRD         = 3,
   parameter bit RESET_ARRAY = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DW-1:0]     wdata,
   input  logic [NRD*AW-1:0] raddr,
   output logic [NRD*DW-1:0] rdata
);

   logic [DW-1:0] mem [DEPTH];

   generate
      if (RESET_ARRAY) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end

      for (genvar p = 0; p < NRD; p++) begin : g_rd
         assign rdata[p*DW +: DW] = mem[raddr[p*AW +: AW]];
      end
   endgenerate

endmodule

// File: rtl/dwrf_wbuf.sv
`timescale 1ns/1ps
module dwrf_wbuf
   import dwrf_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int DW    = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          w0_en,
   input  logic [AW-1:0] w0_addr,
   input  logic [DW-1:0] w0_data,
   input  logic          w1_en,
   input  logic [AW-1:0] w1_addr,
   input  logic [DW-1:0] w1_data,
   output logic          arr_we,
   output logic [AW-1:0] arr_addr,
   output logic [DW-1:0] arr_data,
   output logic          hb_valid,
   output logic [AW-1:0] hb_addr,
   output logic [DW-1:0] hb_data,
   output logic          stall
);

   logic          eff0, eff1, both, one;
   logic [AW-1:0] s_addr;
   logic [DW-1:0] s_data;
   hb_act_e       act;

   always_comb begin
      // R4: port 1 wins on an equal address, port 0 is dropped
      eff0   = w0_en && !(w1_en && (w0_addr == w1_addr));
      eff1   = w1_en;
      both   = eff0 && eff1;
      one    = eff0 ^ eff1;
      s_addr = eff1 ? w1_addr : w0_addr;
      s_data = eff1 ? w1_data : w0_data;

      stall    = 1'b0;
      arr_we   = 1'b0;
      arr_addr = w0_addr;
      arr_data = w0_data;
      act      = HB_KEEP;

      if (!hb_valid) begin
         if (both) begin
            arr_we = 1'b1;
            act    = HB_FILL;
         end else if (one) begin
            arr_we   = 1'b1;
            arr_addr = s_addr;
            arr_data = s_data;
         end
      end else begin
         arr_addr = hb_addr;
         arr_data = hb_data;
         if (one && (s_addr == hb_addr)) begin
            act = HB_REPLACE;
         end else begin
            arr_we = 1'b1;
            act    = HB_DRAIN;
            stall  = eff0 | eff1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hb_valid <= 1'b0;
         hb_addr  <= '0;
         hb_data  <= '0;
      end else begin
         unique case (act)
            HB_FILL: begin
               hb_valid <= 1'b1;
               hb_addr  <= w1_addr;
               hb_data  <= w1_data;
            end
            HB_REPLACE: hb_data  <= s_data;
            HB_DRAIN:   hb_valid <= 1'b0;
            default: ;
         endcase
      end
   end

   // R6: a stall never lasts beyond one cycle
   a_r6_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);

   // R7: a stall always empties the holding register
   a_r7_stall_empties: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !hb_valid);

   // R3: a clean dual write parks port 1
   a_r3_park_port1: assert property (@(posedge clk) disable iff (!rst_n)
      (!hb_valid && both) |=> (hb_valid && hb_addr == $past(w1_addr)
                               && hb_data == $past(w1_data)));

   // R8: in-place replacement keeps the entry and takes the new data
   a_r8_replace: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_valid && one && s_addr == hb_addr && !stall)
         |=> (hb_valid && hb_data == $past(s_data)));

endmodule

// File: rtl/dwrf_fwd.sv
`timescale 1ns/1ps
module dwrf_fwd #(
   parameter int AW = 4,
   parameter int DW = 16
) (
   input  logic [AW-1:0] raddr,
   input  logic [DW-1:0] arr_rdata,
   input  logic          hb_valid,
   input  logic [AW-1:0] hb_addr,
   input  logic [DW-1:0] hb_data,
   output logic [DW-1:0] rdata
);

   logic hit;

   always_comb begin
      hit   = hb_valid && (raddr == hb_addr);
      rdata = hit ? hb_data : arr_rdata;
   end

endmodule

// File: rtl/dwrf_top.sv
`timescale 1ns/1ps
module dwrf_top
   import dwrf_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int DW          = 16,
   parameter int NRD         = 3,
   parameter bit RESET_ARRAY = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              w0_en,
   input  logic [AW-1:0]     w0_addr,
   input  logic [DW-1:0]     w0_data,
   input  logic              w1_en,
   input  logic [AW-1:0]     w1_addr,
   input  logic [DW-1:0]     w1_data,
   input  logic [NRD*AW-1:0] rd_addr,
   output logic [NRD*DW-1:0] rd_data,
   output logic              stall
);

   generate
      if (NRD < 2 || NRD > 3) begin : g_bad_nrd
         $error("dwrf_top: NRD must be 2 or 3");
      end
      if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $error("dwrf_top: DEPTH must be a power of two, at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("dwrf_top: DW must be positive");
      end
   endgenerate

   logic              arr_we;
   logic [AW-1:0]     arr_addr;
   logic [DW-1:0]     arr_data;
   logic              hb_valid;
   logic [AW-1:0]     hb_addr;
   logic [DW-1:0]     hb_data;
   logic [NRD*DW-1:0] arr_rdata;

   dwrf_wbuf #(.DEPTH(DEPTH), .DW(DW)) u_wbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .w0_en    (w0_en),
      .w0_addr  (w0_addr),
      .w0_data  (w0_data),
      .w1_en    (w1_en),
      .w1_addr  (w1_addr),
      .w1_data  (w1_data),
      .arr_we   (arr_we),
      .arr_addr (arr_addr),
      .arr_data (arr_data),
      .hb_valid (hb_valid),
      .hb_addr  (hb_addr),
      .hb_data  (hb_data),
      .stall    (stall)
   );

   dwrf_array #(.DEPTH(DEPTH), .DW(DW), .NRD(NRD), .RESET_ARRAY(RESET_ARRAY)) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (arr_we),
      .waddr (arr_addr),
      .wdata (arr_data),
      .raddr (rd_addr),
      .rdata (arr_rdata)
   );

   generate
      for (genvar p = 0; p < NRD; p++) begin : g_port
         dwrf_fwd #(.AW(AW), .DW(DW)) u_fwd (
            .raddr     (rd_addr[p*AW +: AW]),
            .arr_rdata (arr_rdata[p*DW +: DW]),
            .hb_valid  (hb_valid),
            .hb_addr   (hb_addr),
            .hb_data   (hb_data),
            .rdata     (rd_data[p*DW +: DW])
         );

         // R9: a read that hits the held address returns the held data
         a_r9_forward_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (hb_valid && rd_addr[p*AW +: AW] == hb_addr)
               |-> (rd_data[p*DW +: DW] == hb_data));
      end
   endgenerate

endmodule

// File: tb/tb_dwrf_top.sv
`timescale 1ns/1ps
module tb_dwrf_top;

   localparam int DEPTH = 16;
   localparam int DW    = 16;
   localparam int NRD   = 3;
   localparam int AW    = 4;
   localparam int VW    = 2 + 2*AW + 2*DW + 1;
   localparam int NV    = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              w0_en = 1'b0, w1_en = 1'b0;
   logic [AW-1:0]     w0_addr = '0, w1_addr = '0;
   logic [DW-1:0]     w0_data = '0, w1_data = '0;
   logic [NRD*AW-1:0] rd_addr = '0;
   logic [NRD*DW-1:0] rd_data;
   logic              stall;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   logic [DW-1:0] ref_mem [DEPTH];

   always #4 clk = ~clk;

   dwrf_top #(.DEPTH(DEPTH), .DW(DW), .NRD(NRD)) dut (
      .clk(clk), .rst_n(rst_n),
      .w0_en(w0_en), .w0_addr(w0_addr), .w0_data(w0_data),
      .w1_en(w1_en), .w1_addr(w1_addr), .w1_data(w1_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .stall(stall)
   );

   // {w0_en, w0_addr, w0_data, w1_en, w1_addr, w1_data, expected stall}
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b1, 4'h1, 16'h1111, 1'b0, 4'h0, 16'h0000, 1'b0}, // R2 port 0
      {1'b0, 4'h0, 16'h0000, 1'b1, 4'h2, 16'h2222, 1'b0}, // R2 port 1
      {1'b1, 4'h3, 16'h3333, 1'b1, 4'h4, 16'h4444, 1'b0}, // R3 dual
      {1'b0, 4'h0, 16'h0000, 1'b0, 4'h0, 16'h0000, 1'b0}, // R5 drain, R9 fwd
      {1'b1, 4'h5, 16'h5555, 1'b1, 4'h6, 16'h6666, 1'b0}, // R3 dual
      {1'b1, 4'h7, 16'h7777, 1'b0, 4'h0, 16'h0000, 1'b1}, // R6 stall
      {1'b1, 4'h7, 16'h7777, 1'b0, 4'h0, 16'h0000, 1'b0}, // R7 held retry
      {1'b1, 4'h8, 16'h8888, 1'b1, 4'h8, 16'h9999, 1'b0}, // R4 same addr
      {1'b1, 4'h9, 16'h0A0A, 1'b1, 4'hA, 16'h0B0B, 1'b0}, // R3 dual
      {1'b0, 4'h0, 16'h0000, 1'b1, 4'hA, 16'h0C0C, 1'b0}, // R8 replace
      {1'b0, 4'h0, 16'h0000, 1'b0, 4'h0, 16'h0000, 1'b0}, // R5 drain new
      {1'b1, 4'hB, 16'h1B1B, 1'b1, 4'hC, 16'h1C1C, 1'b0}, // R3 dual
      {1'b1, 4'hC, 16'h2C2C, 1'b1, 4'hD, 16'h2D2D, 1'b1}, // R6 two writes
      {1'b1, 4'hC, 16'h2C2C, 1'b1, 4'hD, 16'h2D2D, 1'b0}, // R7 held retry
      {1'b1, 4'hD, 16'h3D3D, 1'b1, 4'hD, 16'h4D4D, 1'b0}, // R4 + R8
      {1'b0, 4'h0, 16'h0000, 1'b0, 4'h0, 16'h0000, 1'b0}  // R5 drain
   };

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Every address through all read ports in turn (R10), against the model
   task automatic scan(input string tag);
      for (int g = 0; g < (DEPTH + NRD - 1) / NRD; g++) begin
         for (int p = 0; p < NRD; p++)
            rd_addr[p*AW +: AW] = AW'((g*NRD + p) % DEPTH);
         #0.5;
         for (int p = 0; p < NRD; p++)
            if (g*NRD + p < DEPTH)
               check(tag, rd_data[p*DW +: DW], ref_mem[g*NRD + p]);
      end
   endtask

   task automatic clear_inputs();
      w0_en = 1'b0; w1_en = 1'b0;
      w0_addr = '0; w1_addr = '0; w0_data = '0; w1_data = '0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;

      // R1: reset state, even with writes requested
      #1;
      w0_en = 1'b1; w0_addr = 4'h3; w0_data = 16'hDEAD;
      #1;
      check("R1 stall in reset", {15'b0, stall}, 16'h0);
      scan("R1 reset read");
      @(negedge clk);
      scan("R1 reset read held");
      clear_inputs();
      @(negedge clk);
      rst_n = 1'b1;

      // Vector walk: reads after each edge, stall within the cycle
      for (int k = 0; k < NV; k++) begin
         logic [VW-1:0] v;
         v = VEC[k];
         @(negedge clk);
         {w0_en, w0_addr, w0_data, w1_en, w1_addr, w1_data} = v[VW-1:1];
         scan("R2 R3 R4 R5 R7 R8 R9 R10 read");
         #0.25;
         check("R6 stall", {15'b0, stall}, {15'b0, v[0]});
         @(posedge clk);
         if (!v[0]) begin
            if (v[VW-1])                  ref_mem[v[VW-2 -: AW]] = v[VW-2-AW -: DW];
            if (v[VW-2-AW-DW])            ref_mem[v[VW-3-AW-DW -: AW]] = v[VW-3-2*AW-DW -: DW];
         end
      end
      @(negedge clk);
      clear_inputs();
      scan("R5 final read");
      check("R5 no stall after drain", {15'b0, stall}, 16'h0);

      // R9: all ports on the held address at once
      w0_en = 1'b1; w0_addr = 4'hE; w0_data = 16'hE0E0;
      w1_en = 1'b1; w1_addr = 4'hF; w1_data = 16'hF0F0;
      @(posedge clk);
      ref_mem[14] = 16'hE0E0; ref_mem[15] = 16'hF0F0;
      @(negedge clk);
      clear_inputs();
      rd_addr = {4'hF, 4'hF, 4'hF};
      #0.5;
      for (int p = 0; p < NRD; p++)
         check("R9 all ports hit", rd_data[p*DW +: DW], 16'hF0F0);
      rd_addr = {4'hE, 4'hF, 4'h1};
      #0.5;
      check("R10 port 0", rd_data[0 +: DW], 16'h1111);
      check("R10 port 1", rd_data[DW +: DW], 16'hF0F0);
      check("R10 port 2", rd_data[2*DW +: DW], 16'hE0E0);

      // R1: reset while an entry is held clears everything
      @(negedge clk);
      w0_en = 1'b1; w0_addr = 4'h0; w0_data = 16'hAAAA;
      w1_en = 1'b1; w1_addr = 4'h1; w1_data = 16'hBBBB;
      @(posedge clk);
      @(negedge clk);
      w1_en = 1'b0; w0_addr = 4'h2;
      rst_n = 1'b0;
      #0.5;
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      check("R1 stall cleared by reset", {15'b0, stall}, 16'h0);
      scan("R1 reset mid-run");
      clear_inputs();
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule